// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block derives the bit-clock timing and the frame timing for the transmit half of a serial port. Everything runs in one system clock domain. An input-clock enable is picked from one of three sources (every system cycle, or one of two synchronized external strobes) or from a reserved code that stops the generator. A programmable divider turns that enable stream into a one-cycle bit-clock tick, `clkg_tick`. A frame counter clocked by the tick builds a periodic frame pulse, `fsg`, with a programmable period and high time.

A final selector produces the transmit frame sync `fsx`. It either passes an external frame-sync input straight through, or forwards the generator's frame pulse, or emits a one-cycle pulse after a holding-to-shift-register copy event. The configuration inputs are captured into internal registers. Any change to the divide, period or width values restarts both counters on the next input-clock enable, so no shortened pulse reaches the outputs.

Top module: `srg_gen_top`

## Requirements
- R1: While `rst_n` is low, `clkg_tick` and `fsg` read 0. Reset selects the every-cycle source with divide value 1, period value 0 and width value 0. With those values, `clkg_tick` is high once every 2 system cycles and `fsg` stays low.
- R2: With source code {`sel_pin`,`sel_mode`} = 01, every system cycle is an input enable, and `clkg_tick` pulses once every `div_val`+1 system cycles.
- R3: With code 10, only `rclk_stb` strobes are input enables. `clkg_tick` pulses once every `div_val`+1 strobes, and `xclk_stb` has no effect.
- R4: With code 11, only `xclk_stb` strobes are input enables. `clkg_tick` pulses once every `div_val`+1 strobes, and `rclk_stb` has no effect.
- R5: With code 00 (reserved), from the second cycle after the code is applied, `clkg_tick` and `fsg` stay low and the counters hold.
- R6: `fsg` rises once every `frm_per`+1 bit-clock periods. It changes only one cycle after a tick, a restart or entry into the reserved code.
- R7: `fsg` stays high for `frm_wid`+1 bit-clock periods when that is less than `frm_per`+1.
- R8: When `frm_wid`+1 >= `frm_per`+1, the high time is clamped to `frm_per` bit-clock periods. With `frm_per` = 0, `fsg` never goes high.
- R9: With `fs_int_en` = 0, `fsx` equals `ext_fs` in the same cycle. `copy_evt` and `fsg` have no effect.
- R10: With `fs_int_en` = 1 and `fs_gen_sel` = 1, `fsx` equals `fsg`.
- R11: With `fs_int_en` = 1 and `fs_gen_sel` = 0, `fsx` is high for exactly the one cycle after each cycle in which `copy_evt` is high, and otherwise low regardless of `fsg`.
- R12: A change of `div_val`, `frm_per` or `frm_wid` seen at edge E1 restarts the counters at the next input-enable edge E2. At E2, `fsg` and `clkg_tick` go low. The first tick is visible after edge E2+`div_val`+1, and `fsg` rises one edge after that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_pin | input | 1 | Source code high bit (external pin select) |
| sel_mode | input | 1 | Source code low bit |
| rclk_stb | input | 1 | Synchronized receive-clock strobe |
| xclk_stb | input | 1 | Synchronized transmit-clock strobe |
| div_val | input | 8 | Divide value; tick every div_val+1 enables |
| frm_per | input | 12 | Frame period value; period frm_per+1 ticks |
| frm_wid | input | 8 | Frame width value; high frm_wid+1 ticks |
| fs_int_en | input | 1 | 1: internal frame sync, 0: external |
| fs_gen_sel | input | 1 | Internal frame sync source: 1 generator, 0 copy event |
| copy_evt | input | 1 | Holding-to-shift-register copy event |
| ext_fs | input | 1 | External frame-sync input |
| clkg_tick | output | 1 | One-cycle bit-clock tick |
| fsg | output | 1 | Generator frame pulse |
| fsx | output | 1 | Transmit frame sync |

## Verification
`fsx` in external mode is combinational, so it is sampled one time step after the input changes. The copy pulse appears one edge after `copy_evt`. `clkg_tick` is registered one edge after the enable that completes a divide count, and `fsg` moves one edge after the tick it consumes. The restart case counts edges from the detecting edge explicitly. Rate, period and width are measured as distances between samples taken at the falling clock edge. Because of that, these checks do not depend on where the divider phase sits when a configuration is applied, and each table entry waits for several frame periods before measuring.

// File: rtl/srg_pkg.sv
// Package: shared source-select encoding for the sample rate generator.
// Assumes bit 1 of the code is the pin-select bit and bit 0 the mode bit.
package srg_pkg;
    typedef enum logic [1:0] {
        SRC_RSVD = 2'b00,
        SRC_INT  = 2'b01,
        SRC_RCLK = 2'b10,
        SRC_XCLK = 2'b11
    } src_e;
endpackage

// File: rtl/srg_cfg.sv
// Configuration capture and input-clock selection.
// Registers the source code and the divide/period/width values. It flags a
// pending restart when any of those values change, and produces the
// input-enable stream from the chosen source.
// Assumes the strobes are already synchronized single-cycle pulses.
module srg_cfg
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_pin,
    input  logic             sel_mode,
    input  logic             rclk_stb,
    input  logic             xclk_stb,
    input  logic [DIV_W-1:0] div_in,
    input  logic [PER_W-1:0] per_in,
    input  logic [WID_W-1:0] wid_in,
    output logic [DIV_W-1:0] div_q,
    output logic [PER_W-1:0] per_q,
    output logic [WID_W-1:0] wid_q,
    output logic             in_en,
    output logic             restart,
    output logic             pend,
    output logic             reserved
);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1);

    src_e src_q;
    logic chg;

    // Detect a change of any timing value against the captured copy.
    always_comb chg = (div_in != div_q) || (per_in != per_q) || (wid_in != wid_q);

    // Capture configuration; reset picks the every-cycle source, divide-by-two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_INT;
            div_q <= DIV_RST;
            per_q <= '0;
            wid_q <= '0;
            pend  <= 1'b0;
        end else begin
            src_q <= src_e'({sel_pin, sel_mode});
            div_q <= div_in;
            per_q <= per_in;
            wid_q <= wid_in;
            pend  <= chg ? 1'b1 : (in_en ? 1'b0 : pend);
        end
    end

    // Pick the input enable from the captured source code.
    always_comb begin
        unique case (src_q)
            SRC_INT:  in_en = 1'b1;
            SRC_RCLK: in_en = rclk_stb;
            SRC_XCLK: in_en = xclk_stb;
            default:  in_en = 1'b0;
        endcase
    end

    // Restart fires on the first input enable after a change.
    always_comb restart  = pend && in_en;
    always_comb reserved = (src_q == SRC_RSVD);

    AST_PEND_HOLDS_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) && !$past(in_en)) |-> pend);  // R12
endmodule

// File: rtl/srg_div.sv
// Bit-clock divider.
// Counts input enables and emits a one-cycle registered tick on every
// (div_q+1)-th enable. A restart clears the count and suppresses the tick.
// Assumes div_q is stable except when a restart is pending.
module srg_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic             restart,
    input  logic             pend,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Advance the divide count on each enable and flag the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (in_en) begin
                if (restart) begin
                    cnt <= '0;
                end else if (cnt >= div_q) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> (cnt <= div_q));  // R2
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !tick);  // R12
    AST_TICK_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(in_en));  // R3
endmodule

// File: rtl/srg_frame.sv
// Frame pulse generator.
// Steps a position counter on each bit-clock tick through 0..per_q. The
// pulse is high while the position is below the effective width, which is
// wid_q+1 clamped to per_q. A restart parks the counter so that the next
// tick opens a fresh period. The reserved source forces the pulse low.
// Assumes ticks are single-cycle pulses.
module srg_frame #(
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             pend,
    input  logic             reserved,
    input  logic [PER_W-1:0] per_q,
    input  logic [WID_W-1:0] wid_q,
    output logic             fsg
);
    localparam int CW = ((PER_W > WID_W) ? PER_W : WID_W) + 1;

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] nxt;
    logic [CW-1:0]    period;
    logic [CW-1:0]    w1;
    logic [CW-1:0]    eff;

    // Effective width: requested width, clamped to leave one low period.
    always_comb begin
        period = CW'(per_q) + CW'(1);
        w1     = CW'(wid_q) + CW'(1);
        eff    = (w1 >= period) ? CW'(per_q) : w1;
    end

    // Next position in the frame, wrapping after the last one.
    always_comb nxt = (cnt >= per_q) ? '0 : cnt + 1'b1;

    // Update position and pulse on ticks, with restart and reserved first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
            fsg <= 1'b0;
        end else if (restart) begin
            cnt <= '1;
            fsg <= 1'b0;
        end else if (reserved) begin
            fsg <= 1'b0;
        end else if (tick) begin
            cnt <= nxt;
            fsg <= (CW'(nxt) < eff);
        end
    end

    AST_FSG_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (fsg != $past(fsg)) |-> ($past(tick) || $past(restart) || $past(reserved)));  // R6
    AST_FRM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> ((cnt <= per_q) || (cnt == '1)));  // R6
    AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && fsg) |-> (per_q != '0));  // R8
endmodule

// File: rtl/srg_gen_top.sv
// Sample rate generator top.
// Wires configuration capture, the bit-clock divider and the frame pulse
// generator together, and selects the transmit frame sync from the external
// input, the generator pulse or a delayed copy-event pulse.
// Assumes all inputs are synchronous to clk.
module srg_gen_top #(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_pin,
    input  logic             sel_mode,
    input  logic             rclk_stb,
    input  logic             xclk_stb,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PER_W-1:0] frm_per,
    input  logic [WID_W-1:0] frm_wid,
    input  logic             fs_int_en,
    input  logic             fs_gen_sel,
    input  logic             copy_evt,
    input  logic             ext_fs,
    output logic             clkg_tick,
    output logic             fsg,
    output logic             fsx
);
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic [WID_W-1:0] wid_q;
    logic             in_en;
    logic             restart;
    logic             pend;
    logic             reserved;
    logic             copy_q;

    srg_cfg #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .sel_mode(sel_mode),
        .rclk_stb(rclk_stb), .xclk_stb(xclk_stb),
        .div_in(div_val), .per_in(frm_per), .wid_in(frm_wid),
        .div_q(div_q), .per_q(per_q), .wid_q(wid_q),
        .in_en(in_en), .restart(restart), .pend(pend), .reserved(reserved)
    );

    srg_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .restart(restart),
        .pend(pend), .div_q(div_q), .tick(clkg_tick)
    );

    srg_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(clkg_tick), .restart(restart),
        .pend(pend), .reserved(reserved), .per_q(per_q), .wid_q(wid_q),
        .fsg(fsg)
    );

    // Delay the copy event by one cycle to form the copy-driven sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) copy_q <= 1'b0;
        else        copy_q <= copy_evt;
    end

    // Select the transmit frame-sync source.
    always_comb begin
        if (!fs_int_en)     fsx = ext_fs;
        else if (fs_gen_sel) fsx = fsg;
        else                 fsx = copy_q;
    end

    AST_COPY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_int_en && !fs_gen_sel && fsx) |-> $past(copy_evt));  // R11
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved && $past(reserved)) |-> (!clkg_tick && !fsg));  // R5
endmodule

// File: tb/tb_srg_gen_top.sv
module tb_srg_gen_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  div;
        logic [11:0] per;
        logic [7:0]  wid;
        int          e_tick;
        int          e_per;
        int          e_wid;
        int          req;
    } vec_t;

    // rclk_stb every 3 cycles, xclk_stb every 5 cycles.
    localparam vec_t VEC [7] = '{
        '{2'b01, 8'd1, 12'd3, 8'd0, 2,  8,  2, 2},
        '{2'b01, 8'd4, 12'd2, 8'd1, 5,  15, 10, 7},
        '{2'b10, 8'd1, 12'd4, 8'd1, 6,  30, 12, 3},
        '{2'b11, 8'd0, 12'd3, 8'd2, 5,  20, 15, 4},
        '{2'b01, 8'd0, 12'd3, 8'd7, 1,  4,  3, 8},
        '{2'b01, 8'd2, 12'd5, 8'd5, 3,  18, 15, 8},
        '{2'b10, 8'd0, 12'd1, 8'd0, 3,  6,  3, 6}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic sel_pin, sel_mode, rclk_stb, xclk_stb;
    logic [7:0]  div_val;
    logic [11:0] frm_per;
    logic [7:0]  frm_wid;
    logic fs_int_en, fs_gen_sel, copy_evt, ext_fs;
    logic clkg_tick, fsg, fsx;

    int n_run = 0;
    int n_fail = 0;

    srg_gen_top dut (
        .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .sel_mode(sel_mode),
        .rclk_stb(rclk_stb), .xclk_stb(xclk_stb), .div_val(div_val),
        .frm_per(frm_per), .frm_wid(frm_wid), .fs_int_en(fs_int_en),
        .fs_gen_sel(fs_gen_sel), .copy_evt(copy_evt), .ext_fs(ext_fs),
        .clkg_tick(clkg_tick), .fsg(fsg), .fsx(fsx)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // External strobe generators, driven at the falling edge.
    initial begin
        int rc = 0;
        int xc = 0;
        rclk_stb = 1'b0;
        xclk_stb = 1'b0;
        forever begin
            @(negedge clk);
            rclk_stb = (rc == 0);
            xclk_stb = (xc == 0);
            rc = (rc == 2) ? 0 : rc + 1;
            xc = (xc == 4) ? 0 : xc + 1;
        end
    end

    // Cycles between consecutive tick samples.
    task automatic meas_tick(output int iv);
        int g = 0;
        do begin @(negedge clk); g++; end while (!clkg_tick && g < 500);
        iv = 0;
        do begin @(negedge clk); iv++; end while (!clkg_tick && iv < 500);
    endtask

    // Rise-to-fall (width) and rise-to-rise (period) of fsg in cycles.
    task automatic meas_fsg(output int w, output int p);
        int g = 0;
        do begin @(negedge clk); g++; end while (fsg && g < 500);
        do begin @(negedge clk); g++; end while (!fsg && g < 1000);
        w = 0;
        do begin @(negedge clk); w++; end while (fsg && w < 500);
        p = w;
        do begin @(negedge clk); p++; end while (!fsg && p < 1000);
    endtask

    task automatic apply(input vec_t v);
        {sel_pin, sel_mode} = v.sel;
        div_val = v.div;
        frm_per = v.per;
        frm_wid = v.wid;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int iv, w, p, bad;
        rst_n = 1'b0;
        sel_pin = 1'b0; sel_mode = 1'b1;
        div_val = 8'd1; frm_per = 12'd0; frm_wid = 8'd0;
        fs_int_en = 1'b1; fs_gen_sel = 1'b1; copy_evt = 1'b0; ext_fs = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        chk(!clkg_tick && !fsg, "R1 reset idle", {clkg_tick, fsg}, 0);
        rst_n = 1'b1;
        meas_tick(iv);
        chk(iv == 2, "R1 default half rate", iv, 2);
        bad = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (fsg) bad++; end
        chk(bad == 0, "R1 R8 no frame at period 0", bad, 0);

        // Table-driven rate, period and width checks (R2 R3 R4 R6 R7 R8).
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            apply(VEC[k]);
            repeat (120) @(negedge clk);
            meas_tick(iv);
            chk(iv == VEC[k].e_tick, $sformatf("R%0d vec%0d tick interval", VEC[k].req, k), iv, VEC[k].e_tick);
            meas_fsg(w, p);
            chk(p == VEC[k].e_per, $sformatf("R6 vec%0d frame period", k), p, VEC[k].e_per);
            chk(w == VEC[k].e_wid, $sformatf("R7 vec%0d frame width", k), w, VEC[k].e_wid);
        end

        // R10: fsx follows the generator pulse; copy_evt ignored.
        @(negedge clk);
        apply('{2'b01, 8'd0, 12'd3, 8'd0, 0, 0, 0, 0});
        fs_int_en = 1'b1; fs_gen_sel = 1'b1;
        repeat (20) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            copy_evt = (i % 7 == 0);
            #1;
            if (fsx !== fsg) bad++;
        end
        copy_evt = 1'b0;
        chk(bad == 0, "R10 fsx equals fsg", bad, 0);

        // R11: copy-driven pulse, fsg ignored.
        fs_gen_sel = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (fsx) bad++; end
        chk(bad == 0, "R11 fsx low without copy", bad, 0);
        @(negedge clk); copy_evt = 1'b1;
        @(negedge clk); copy_evt = 1'b0; #1;
        chk(fsx == 1'b1, "R11 pulse after copy", fsx, 1);
        @(negedge clk); #1;
        chk(fsx == 1'b0, "R11 pulse one cycle", fsx, 0);

        // R9: external pass-through, copy_evt ignored.
        fs_int_en = 1'b0;
        @(negedge clk); ext_fs = 1'b1; copy_evt = 1'b1; #1;
        chk(fsx == 1'b1, "R9 ext high", fsx, 1);
        @(negedge clk); ext_fs = 1'b0; copy_evt = 1'b0; #1;
        chk(fsx == 1'b0, "R9 ext low after copy", fsx, 0);
        fs_int_en = 1'b1; fs_gen_sel = 1'b1;

        // R12: restart after a divide change.
        @(negedge clk);
        apply('{2'b01, 8'd2, 12'd3, 8'd0, 0, 0, 0, 0});
        repeat (60) @(negedge clk);
        div_val = 8'd3;
        @(posedge clk);
        @(posedge clk); #1;
        chk(!fsg && !clkg_tick, "R12 restart clears", {fsg, clkg_tick}, 0);
        iv = 0;
        do begin @(posedge clk); #1; iv++; end while (!clkg_tick && iv < 20);
        chk(iv == 4, "R12 first tick edge", iv, 4);
        chk(fsg == 1'b0, "R12 fsg low at tick", fsg, 0);
        @(posedge clk); #1;
        chk(fsg == 1'b1, "R12 fsg rises after tick", fsg, 1);

        // R5: reserved code stops everything.
        @(negedge clk);
        apply('{2'b01, 8'd0, 12'd1, 8'd0, 0, 0, 0, 0});
        repeat (10) @(negedge clk);
        {sel_pin, sel_mode} = 2'b00;
        repeat (3) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (clkg_tick || fsg) bad++; end
        chk(bad == 0, "R5 reserved idle", bad, 0);

        finish_run();
    end
endmodule